// File: doc/BRIEF.md
# Branch Record Store Buffer Writer

This block sits behind a core's branch retirement logic and turns each retired-branch event into one fixed-size record written to a buffer in memory. Every record carries the branch source address, the branch target address and a flags word holding the privilege level at which the branch retired. Software describes the buffer with four values: a base address, the current write index, an absolute upper limit and an interrupt threshold. It loads the index once before tracing starts and reads the updated index back from the block.

Control inputs gate recording as a whole, mask out kernel-level (level 0) or user-level (levels 1 to 3) branches, and pick one of two policies for a full buffer. In circular mode the writer wraps back to the base and never interrupts. In interrupt mode it raises a sticky interrupt once the index crosses the threshold, and it drops further branches when no room is left, setting a sticky overflow flag.

Records leave on a single-beat valid/ready write port. While a record waits on that port, the event input pushes back through its own ready signal.

Top module: `brlog_writer`

## Requirements
- R1: After a synchronous reset, `idx_out` is 0, `irq` and `overflow` are 0, `mem_valid` is 0 and `ev_ready` is 1.
- R2: While `cfg_enable` is 0, accepted events produce no memory write and leave `idx_out` unchanged.
- R3: An event with `ev_priv` equal to 0 is ignored when `cfg_skip_kernel` is 1. An event with `ev_priv` equal to 1, 2 or 3 is ignored when `cfg_skip_user` is 1. An ignored event produces no write and leaves the index as it was.
- R4: A recorded branch is written with `mem_data[31:0]` = source, `mem_data[63:32]` = destination and `mem_data[95:64]` = flags. In the flags word, bits [1:0] hold the privilege level and all other bits are 0.
- R5: A record that fits (index + 12 <= limit) is written at the current index, and `idx_out` then advances by 12 on the clock edge that accepts the event.
- R6: With `cfg_irq_mode` = 0, a record that does not fit is written at `buf_base` and the index becomes `buf_base` + 12. `irq` never rises in this mode.
- R7: With `cfg_irq_mode` = 1, `irq` is set on the edge where a record is written and the new index is >= `buf_thresh`. It then stays at 1 until `irq_ack` is high on a clock edge. A set in the same cycle wins over the acknowledge.
- R8: With `cfg_irq_mode` = 1, an enabled event that does not fit is dropped with no write and no index change, and `overflow` is set. `overflow` stays at 1 until `irq_ack`.
- R9: While `mem_valid` is 1 and `mem_ready` is 0, `mem_valid`, `mem_addr` and `mem_data` hold. `ev_ready` is 1 exactly when the write port is empty or completing this cycle and `idx_wr` is 0.
- R10: `idx_wr` loads `idx_wdata` into the index on the next edge, and `ev_ready` is 0 in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_valid | input | 1 | Retired-branch event present |
| ev_ready | output | 1 | Event accepted on this edge when high |
| ev_src | input | 32 | Branch source address |
| ev_dst | input | 32 | Branch destination address |
| ev_priv | input | 2 | Privilege level of the branch |
| cfg_enable | input | 1 | Master recording enable |
| cfg_skip_kernel | input | 1 | Ignore level-0 branches |
| cfg_skip_user | input | 1 | Ignore level 1-3 branches |
| cfg_irq_mode | input | 1 | 1: interrupt on full, 0: circular |
| buf_base | input | 32 | Buffer base address |
| buf_limit | input | 32 | Absolute upper address limit |
| buf_thresh | input | 32 | Interrupt threshold address |
| idx_wr | input | 1 | Load the write index |
| idx_wdata | input | 32 | Value to load into the index |
| irq_ack | input | 1 | Clears `irq` and `overflow` |
| idx_out | output | 32 | Current write index |
| irq | output | 1 | Sticky buffer interrupt |
| overflow | output | 1 | Sticky dropped-record flag |
| mem_valid | output | 1 | Record write pending |
| mem_ready | input | 1 | Memory accepts the write |
| mem_addr | output | 32 | Record address |
| mem_data | output | 96 | Record contents |

## Verification
The event stream is driven randomly across every combination of enable, the two privilege masks and the full-buffer policy. Random privilege levels show whether a branch was filtered by the wrong mask. Random write-port stalls separate correct backpressure from lost or duplicated records. A small buffer, only a few records deep, forces frequent wraps in circular mode and frequent threshold crossings, drops and acknowledge collisions in interrupt mode. This exposes an off-by-one in the fit test or a threshold compared against the old index instead of the new one. Directed steps load the index just below the limit and check where the next record lands.

// File: rtl/brlog_pkg.sv
package brlog_pkg;
    localparam int ADDR_W    = 32;
    localparam int FLAG_W    = 32;
    localparam int PRIV_W    = 2;
    localparam int REC_W     = FLAG_W + 2 * ADDR_W;
    localparam int REC_BYTES = REC_W / 8;

    typedef struct packed {
        logic [FLAG_W-1:0] flags;
        logic [ADDR_W-1:0] dst;
        logic [ADDR_W-1:0] src;
    } rec_t;

    function automatic logic priv_masked(input logic [PRIV_W-1:0] priv,
                                         input logic skip_kernel,
                                         input logic skip_user);
        return (priv == '0) ? skip_kernel : skip_user;
    endfunction

    function automatic logic [FLAG_W-1:0] make_flags(input logic [PRIV_W-1:0] priv);
        logic [FLAG_W-1:0] f;
        f = '0;
        f[PRIV_W-1:0] = priv;
        return f;
    endfunction
endpackage

// File: rtl/brlog_filter.sv
module brlog_filter
    import brlog_pkg::*;
(
    input  logic              accept,
    input  logic              enable,
    input  logic              skip_kernel,
    input  logic              skip_user,
    input  logic [PRIV_W-1:0] priv,
    input  logic [ADDR_W-1:0] src,
    input  logic [ADDR_W-1:0] dst,
    output logic              keep,
    output rec_t              rec
);
    always_comb begin
        keep      = accept && enable && !priv_masked(priv, skip_kernel, skip_user);
        rec.src   = src;
        rec.dst   = dst;
        rec.flags = make_flags(priv);
    end
endmodule

// File: rtl/brlog_index.sv
module brlog_index
    import brlog_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              keep,
    input  logic              irq_mode,
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] limit,
    input  logic [ADDR_W-1:0] thresh,
    input  logic              idx_wr,
    input  logic [ADDR_W-1:0] idx_wdata,
    input  logic              irq_ack,
    output logic              wr_go,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [ADDR_W-1:0] idx_q,
    output logic              irq_q,
    output logic              ovf_q
);
    localparam logic [ADDR_W:0] REC_EXT = (ADDR_W+1)'(REC_BYTES);

    logic [ADDR_W:0]   idx_end;
    logic              room;
    logic [ADDR_W-1:0] idx_nxt;
    logic              irq_set;
    logic              ovf_set;

    always_comb begin
        idx_end = {1'b0, idx_q} + REC_EXT;
        room    = idx_end <= {1'b0, limit};
        wr_go   = 1'b0;
        wr_addr = idx_q;
        idx_nxt = idx_q;
        irq_set = 1'b0;
        ovf_set = 1'b0;
        if (keep) begin
            if (room) begin
                wr_go   = 1'b1;
                wr_addr = idx_q;
                idx_nxt = idx_end[ADDR_W-1:0];
                irq_set = irq_mode && (idx_end[ADDR_W-1:0] >= thresh);
            end else if (irq_mode) begin
                ovf_set = 1'b1;
            end else begin
                wr_go   = 1'b1;
                wr_addr = base;
                idx_nxt = base + ADDR_W'(REC_BYTES);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q <= '0;
            irq_q <= 1'b0;
            ovf_q <= 1'b0;
        end else begin
            if (idx_wr) idx_q <= idx_wdata;
            else        idx_q <= idx_nxt;
            if (irq_set)      irq_q <= 1'b1;
            else if (irq_ack) irq_q <= 1'b0;
            if (ovf_set)      ovf_q <= 1'b1;
            else if (irq_ack) ovf_q <= 1'b0;
        end
    end

    assert_irq_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        (irq_q && !irq_ack) |=> irq_q);
    assert_no_irq_circular_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_q) |-> $past(irq_mode));
    assert_ovf_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        $fell(ovf_q) |-> $past(irq_ack));
    assert_drop_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (ovf_set && !idx_wr) |=> $stable(idx_q));
endmodule

// File: rtl/brlog_port.sv
module brlog_port
    import brlog_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_addr,
    input  rec_t              load_rec,
    input  logic              mem_ready,
    output logic              can_take,
    output logic              mem_valid,
    output logic [ADDR_W-1:0] mem_addr,
    output rec_t              mem_rec
);
    always_comb can_take = !mem_valid || mem_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            mem_valid <= 1'b0;
            mem_addr  <= '0;
            mem_rec   <= '0;
        end else begin
            if (load) begin
                mem_valid <= 1'b1;
                mem_addr  <= load_addr;
                mem_rec   <= load_rec;
            end else if (mem_ready) begin
                mem_valid <= 1'b0;
            end
        end
    end

    assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_rec)));
endmodule

// File: rtl/brlog_writer.sv
module brlog_writer
    import brlog_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ev_valid,
    output logic              ev_ready,
    input  logic [ADDR_W-1:0] ev_src,
    input  logic [ADDR_W-1:0] ev_dst,
    input  logic [PRIV_W-1:0] ev_priv,
    input  logic              cfg_enable,
    input  logic              cfg_skip_kernel,
    input  logic              cfg_skip_user,
    input  logic              cfg_irq_mode,
    input  logic [ADDR_W-1:0] buf_base,
    input  logic [ADDR_W-1:0] buf_limit,
    input  logic [ADDR_W-1:0] buf_thresh,
    input  logic              idx_wr,
    input  logic [ADDR_W-1:0] idx_wdata,
    input  logic              irq_ack,
    output logic [ADDR_W-1:0] idx_out,
    output logic              irq,
    output logic              overflow,
    output logic              mem_valid,
    input  logic              mem_ready,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [REC_W-1:0]  mem_data
);
    logic              can_take;
    logic              accept;
    logic              keep;
    rec_t              rec;
    logic              wr_go;
    logic [ADDR_W-1:0] wr_addr;
    rec_t              mem_rec;

    always_comb begin
        ev_ready = can_take && !idx_wr;
        accept   = ev_valid && ev_ready;
        mem_data = mem_rec;
    end

    brlog_filter u_filter (
        .accept      (accept),
        .enable      (cfg_enable),
        .skip_kernel (cfg_skip_kernel),
        .skip_user   (cfg_skip_user),
        .priv        (ev_priv),
        .src         (ev_src),
        .dst         (ev_dst),
        .keep        (keep),
        .rec         (rec)
    );

    brlog_index u_index (
        .clk       (clk),
        .rst       (rst),
        .keep      (keep),
        .irq_mode  (cfg_irq_mode),
        .base      (buf_base),
        .limit     (buf_limit),
        .thresh    (buf_thresh),
        .idx_wr    (idx_wr),
        .idx_wdata (idx_wdata),
        .irq_ack   (irq_ack),
        .wr_go     (wr_go),
        .wr_addr   (wr_addr),
        .idx_q     (idx_out),
        .irq_q     (irq),
        .ovf_q     (overflow)
    );

    brlog_port u_port (
        .clk       (clk),
        .rst       (rst),
        .load      (wr_go),
        .load_addr (wr_addr),
        .load_rec  (rec),
        .mem_ready (mem_ready),
        .can_take  (can_take),
        .mem_valid (mem_valid),
        .mem_addr  (mem_addr),
        .mem_rec   (mem_rec)
    );

    assert_ignore_disabled_R2: assert property (@(posedge clk) disable iff (rst)
        (accept && !cfg_enable) |=> !mem_valid);
    assert_ignore_kernel_R3: assert property (@(posedge clk) disable iff (rst)
        (accept && ev_priv == '0 && cfg_skip_kernel) |=> !mem_valid);
    assert_idx_load_R10: assert property (@(posedge clk) disable iff (rst)
        idx_wr |=> (idx_out == $past(idx_wdata)));
endmodule

// File: tb/brlog_writer_tb.sv
module brlog_writer_tb_top;
    import brlog_pkg::*;

    localparam logic [31:0] BASE  = 32'h0000_1000;
    localparam logic [31:0] LIMIT = BASE + 32'd72;
    localparam logic [31:0] THR   = BASE + 32'd48;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic        ev_valid = 0, cfg_enable = 0, cfg_skip_kernel = 0, cfg_skip_user = 0;
    logic        cfg_irq_mode = 0, idx_wr = 0, irq_ack = 0, mem_ready = 0;
    logic [31:0] ev_src = 0, ev_dst = 0, idx_wdata = 0;
    logic [1:0]  ev_priv = 0;
    logic        ev_ready, irq, overflow, mem_valid;
    logic [31:0] idx_out, mem_addr;
    logic [95:0] mem_data;

    brlog_writer dut_i (
        .clk(clk), .rst(rst), .ev_valid(ev_valid), .ev_ready(ev_ready),
        .ev_src(ev_src), .ev_dst(ev_dst), .ev_priv(ev_priv),
        .cfg_enable(cfg_enable), .cfg_skip_kernel(cfg_skip_kernel),
        .cfg_skip_user(cfg_skip_user), .cfg_irq_mode(cfg_irq_mode),
        .buf_base(BASE), .buf_limit(LIMIT), .buf_thresh(THR),
        .idx_wr(idx_wr), .idx_wdata(idx_wdata), .irq_ack(irq_ack),
        .idx_out(idx_out), .irq(irq), .overflow(overflow),
        .mem_valid(mem_valid), .mem_ready(mem_ready),
        .mem_addr(mem_addr), .mem_data(mem_data)
    );

    int n_chk = 0;
    int n_bad = 0;
    int cycles = 0;

    // bench model state
    logic        m_pend = 0;
    logic [31:0] m_addr = 0;
    logic [95:0] m_data = 0;
    logic [31:0] m_idx = 0;
    logic        m_irq = 0, m_ovf = 0;

    task automatic chk(input logic ok, input string tag, input logic [95:0] act, input logic [95:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic model_masked(input logic [1:0] p);
        return (p == 2'd0) ? cfg_skip_kernel : cfg_skip_user;
    endfunction

    function automatic logic [95:0] model_rec(input logic [31:0] s, input logic [31:0] d, input logic [1:0] p);
        return {30'd0, p, d, s};
    endfunction

    task automatic compare_outputs();
        logic exp_ready;
        exp_ready = (!m_pend || mem_ready) && !idx_wr;
        chk(ev_ready == exp_ready, "R9 ev_ready", 96'(ev_ready), 96'(exp_ready));
        chk(mem_valid == m_pend, "R9 mem_valid", 96'(mem_valid), 96'(m_pend));
        if (m_pend) begin
            chk(mem_addr == m_addr, "R5 mem_addr", 96'(mem_addr), 96'(m_addr));
            chk(mem_data == m_data, "R4 mem_data", mem_data, m_data);
        end
        chk(idx_out == m_idx, "R5 idx_out", 96'(idx_out), 96'(m_idx));
        chk(irq == m_irq, "R7 irq", 96'(irq), 96'(m_irq));
        chk(overflow == m_ovf, "R8 overflow", 96'(overflow), 96'(m_ovf));
    endtask

    // advance the model across the coming edge, using inputs already driven
    task automatic model_edge();
        logic acc, set_i, set_o;
        logic [32:0] fin;
        acc   = ev_valid && (!m_pend || mem_ready) && !idx_wr;
        set_i = 0;
        set_o = 0;
        if (m_pend && mem_ready) m_pend = 0;
        if (idx_wr) m_idx = idx_wdata;
        else if (acc && cfg_enable && !model_masked(ev_priv)) begin
            fin = {1'b0, m_idx} + 33'd12;
            if (fin <= {1'b0, LIMIT}) begin
                m_pend = 1; m_addr = m_idx;
                m_data = model_rec(ev_src, ev_dst, ev_priv);
                m_idx  = fin[31:0];
                if (cfg_irq_mode && m_idx >= THR) set_i = 1;
            end else if (cfg_irq_mode) begin
                set_o = 1;
            end else begin
                m_pend = 1; m_addr = BASE;
                m_data = model_rec(ev_src, ev_dst, ev_priv);
                m_idx  = BASE + 32'd12;
            end
        end
        if (set_i) m_irq = 1; else if (irq_ack) m_irq = 0;
        if (set_o) m_ovf = 1; else if (irq_ack) m_ovf = 0;
    endtask

    task automatic cycle_end();
        model_edge();
        @(posedge clk);
        @(negedge clk);
        cycles++;
    endtask

    task automatic load_idx(input logic [31:0] v);
        ev_valid = 0; irq_ack = 0; idx_wr = 1; idx_wdata = v;
        #1;
        chk(ev_ready == 1'b0, "R10 ready low during load", 96'(ev_ready), 96'd0);
        cycle_end();
        idx_wr = 0;
        #1;
        chk(idx_out == v, "R10 index loaded", 96'(idx_out), 96'(v));
    endtask

    task automatic rand_cycle(input int rdy_pct);
        ev_valid  = ($urandom % 100) < 70;
        ev_src    = $urandom;
        ev_dst    = $urandom;
        ev_priv   = 2'($urandom % 4);
        mem_ready = ($urandom % 100) < rdy_pct;
        irq_ack   = ($urandom % 100) < 6;
        #1;
        compare_outputs();
        cycle_end();
    endtask

    initial begin
        #(8 * 150000);
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst = 0;
        #1;
        // R1 reset state
        chk(idx_out == 0, "R1 idx", 96'(idx_out), 96'd0);
        chk(irq == 0 && overflow == 0, "R1 irq/overflow", 96'({irq, overflow}), 96'd0);
        chk(mem_valid == 0, "R1 mem_valid", 96'(mem_valid), 96'd0);
        chk(ev_ready == 1, "R1 ev_ready", 96'(ev_ready), 96'd1);

        // R10 load index, R6 directed wrap at limit
        load_idx(LIMIT - 32'd8);
        cfg_enable = 1; cfg_irq_mode = 0; mem_ready = 1;
        ev_valid = 1; ev_src = 32'hAAAA_0001; ev_dst = 32'hBBBB_0002; ev_priv = 2'd3;
        #1; compare_outputs(); cycle_end();
        ev_valid = 0; #1;
        chk(mem_addr == BASE, "R6 wrap to base", 96'(mem_addr), 96'(BASE));
        chk(idx_out == BASE + 32'd12, "R6 index after wrap", 96'(idx_out), 96'(BASE + 32'd12));
        chk(mem_data == model_rec(32'hAAAA_0001, 32'hBBBB_0002, 2'd3), "R4 record layout",
            mem_data, model_rec(32'hAAAA_0001, 32'hBBBB_0002, 2'd3));
        cycle_end();

        // R8 directed drop at exact fill
        cfg_irq_mode = 1;
        load_idx(LIMIT);
        ev_valid = 1; ev_priv = 2'd1; #1; compare_outputs(); cycle_end();
        ev_valid = 0; #1;
        chk(overflow == 1'b1, "R8 overflow on full", 96'(overflow), 96'd1);
        chk(idx_out == LIMIT, "R8 index held on drop", 96'(idx_out), 96'(LIMIT));
        chk(mem_valid == 1'b0, "R8 no write on drop", 96'(mem_valid), 96'd0);
        irq_ack = 1; #1; compare_outputs(); cycle_end(); irq_ack = 0;

        // random phases over every control combination (R2, R3, R5-R9)
        for (int cfg = 0; cfg < 16; cfg++) begin
            cfg_enable      = cfg[0];
            cfg_skip_kernel = cfg[1];
            cfg_skip_user   = cfg[2];
            cfg_irq_mode    = cfg[3];
            load_idx(BASE);
            for (int k = 0; k < 400; k++) rand_cycle((k < 200) ? 50 : 90);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule